// File: doc/BRIEF.md
# RAM-Backed Tapped Delay Line

This block is a multi-tap delay line for local sample storage next to FIR filters and correlators. It takes one `DATA_W`-bit sample on each cycle where `shift_en` is high. It presents `NUM_TAPS` outputs spaced `TAP_LEN` shifts apart, so tap k gives the sample from (k+1)·`TAP_LEN` shifts earlier. Cycles where `shift_en` is low do not count toward any delay.

The samples are not held in a flip-flop chain. They live in an inferred memory of `TAP_LEN` words, and each word is `NUM_TAPS`·`DATA_W` bits wide. A write pointer walks this memory as a ring. On a shift, the word at the pointer is read. Its lower segments slide up by one, the new sample enters at the bottom, and the result is written back to the same word. The total storage is `DATA_W`·`TAP_LEN`·`NUM_TAPS` bits.

The oldest tap is also driven on a separate output, so a second instance can take it as its input to form a longer line.

Top module: `ram_tap_delay`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every tap segment and `cascade_o` read zero.
- R2: While `shift_en` is low, `taps_o` and `cascade_o` hold their values, whatever `din` carries.
- R3: Tap k is the field `taps_o[k*DATA_W +: DATA_W]`, with k = 0 being the shortest delay. After the j-th shift, tap k equals the sample taken on shift j-(k+1)·`TAP_LEN`. It updates on the clock edge that accepts the shift and is visible right after that edge.
- R4: After the j-th shift since reset, tap k reads zero whenever j ≤ (k+1)·`TAP_LEN`. In particular, the last tap stays zero through the first `TAP_LEN`·`NUM_TAPS` shifts.
- R5: `cascade_o` always equals the last tap, `NUM_TAPS`-1.
- R6: The ring pointer advances by one on each shift and wraps from `TAP_LEN`-1 to 0. It never leaves the range 0 to `TAP_LEN`-1.
- R7: When a word is read and rewritten in the same shift cycle, the taps show the contents from before that write.
- R8: Delays are counted in shifts, not cycles. Idle cycles between shifts do not change which sample a tap shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Accept `din` and advance the line this cycle |
| din | input | DATA_W | New sample |
| taps_o | output | NUM_TAPS*DATA_W | Registered tap outputs, tap k in bits [k*DATA_W +: DATA_W] |
| cascade_o | output | DATA_W | Oldest tap, for feeding a further instance |

## Verification
Every shift both reads a memory word and rewrites that same word. The read must return the old contents while the write lands, so each shift is a read-during-write to one address. Runs of back-to-back shifts wrap the pointer many times, and a scoreboard of every pushed sample judges each tap on each cycle. A wrong sample on any tap shows that the read saw new data instead of old. A second case provokes the zero-masking boundary at the exact shift where a tap first becomes live, and the same comparison judges it. A mid-run reset repeats this boundary case from an empty line.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

    // Bits needed to index `count` distinct values (at least one bit)
    function automatic int idx_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/rtd_ring_ctrl.sv
// Ring pointer and saturating fill count (shifts since reset)
module rtd_ring_ctrl #(
    parameter int DEPTH    = 4,
    parameter int FILL_MAX = 12,
    parameter int PTR_W    = 2,
    parameter int FILL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [FILL_W-1:0] fill_o
);

    localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(FILL_MAX);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [FILL_W-1:0] fill;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (shift_en) begin
            if (ctrl_q.ptr == PTR_LAST) begin
                ctrl_d.ptr = '0;
            end else begin
                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
            end
            if (ctrl_q.fill != FILL_TOP) begin
                ctrl_d.fill = ctrl_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ptr_o  = ctrl_q.ptr;
    assign fill_o = ctrl_q.fill;

endmodule

// File: rtl/rtd_ring_store.sv
// Inferred ring memory: asynchronous read, synchronous write, same address
module rtd_ring_store #(
    parameter int DEPTH   = 4,
    parameter int ENTRY_W = 24,
    parameter int PTR_W   = 2
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   addr,
    input  logic [ENTRY_W-1:0] wr_word,
    output logic [ENTRY_W-1:0] rd_word
);

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    // Read returns the stored word; a write in this cycle lands at the edge
    assign rd_word = mem_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wr_word;
        end
    end

endmodule

// File: rtl/rtd_tap_out.sv
// Tap output registers with per-tap zero masking until a tap holds real data
module rtd_tap_out #(
    parameter int DATA_W   = 8,
    parameter int TAP_LEN  = 4,
    parameter int NUM_TAPS = 3,
    parameter int FILL_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic [NUM_TAPS*DATA_W-1:0]   rd_word,
    input  logic [FILL_W-1:0]            fill,
    output logic [NUM_TAPS*DATA_W-1:0]   taps_o
);

    typedef struct packed {
        logic [NUM_TAPS*DATA_W-1:0] taps;
    } out_t;

    out_t out_d, out_q;
    logic [NUM_TAPS-1:0] live;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_live
        localparam logic [FILL_W-1:0] THRESH = FILL_W'((k + 1) * TAP_LEN);
        assign live[k] = (fill >= THRESH);
    end

    always_comb begin
        out_d = out_q;
        if (shift_en) begin
            for (int k = 0; k < NUM_TAPS; k++) begin
                out_d.taps[k*DATA_W +: DATA_W] =
                    live[k] ? rd_word[k*DATA_W +: DATA_W] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign taps_o = out_q.taps;

endmodule

// File: rtl/ram_tap_delay.sv
module ram_tap_delay #(
    parameter int DATA_W   = 8,
    parameter int TAP_LEN  = 4,
    parameter int NUM_TAPS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [DATA_W-1:0]          din,
    output logic [NUM_TAPS*DATA_W-1:0] taps_o,
    output logic [DATA_W-1:0]          cascade_o
);

    import rtd_pkg::*;

    localparam int ENTRY_W  = NUM_TAPS * DATA_W;
    localparam int FILL_MAX = TAP_LEN * NUM_TAPS;
    localparam int PTR_W    = idx_bits(TAP_LEN);
    localparam int FILL_W   = idx_bits(FILL_MAX + 1);

    logic [PTR_W-1:0]   rd_ptr;
    logic [FILL_W-1:0]  fill;
    logic [ENTRY_W-1:0] rd_word;
    logic [ENTRY_W-1:0] wr_word;

    rtd_ring_ctrl #(
        .DEPTH   (TAP_LEN),
        .FILL_MAX(FILL_MAX),
        .PTR_W   (PTR_W),
        .FILL_W  (FILL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .ptr_o   (rd_ptr),
        .fill_o  (fill)
    );

    // Slide segments up by one; the new sample enters segment 0
    if (NUM_TAPS > 1) begin : g_pack_multi
        assign wr_word = {rd_word[(NUM_TAPS-1)*DATA_W-1:0], din};
    end else begin : g_pack_single
        assign wr_word = din;
    end

    rtd_ring_store #(
        .DEPTH  (TAP_LEN),
        .ENTRY_W(ENTRY_W),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (shift_en),
        .addr   (rd_ptr),
        .wr_word(wr_word),
        .rd_word(rd_word)
    );

    rtd_tap_out #(
        .DATA_W  (DATA_W),
        .TAP_LEN (TAP_LEN),
        .NUM_TAPS(NUM_TAPS),
        .FILL_W  (FILL_W)
    ) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .rd_word (rd_word),
        .fill    (fill),
        .taps_o  (taps_o)
    );

    assign cascade_o = taps_o[(NUM_TAPS-1)*DATA_W +: DATA_W];

endmodule

// File: rtl/ram_tap_delay_chk.sv
module ram_tap_delay_chk #(
    parameter int W     = 8,
    parameter int M     = 4,
    parameter int N     = 3,
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic [N*W-1:0]   taps_o,
    input logic [W-1:0]     cascade_o,
    input logic [PTR_W-1:0] rd_ptr
);

    localparam int CW = $clog2(M * N + 2);
    localparam logic [CW-1:0]    SAT     = CW'(M * N + 1);
    localparam logic [CW-1:0]    LAST_LIM = CW'(M * N);
    localparam logic [CW-1:0]    FIRST_LIM = CW'(M);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(M - 1);

    // Independent count of shifts since reset (saturating)
    logic [CW-1:0] sh_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cnt_q <= '0;
        end else if (shift_en && sh_cnt_q != SAT) begin
            sh_cnt_q <= sh_cnt_q + 1'b1;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(taps_o) && $stable(rd_ptr)));

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && rd_ptr == PTR_LAST) |=> (rd_ptr == '0));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && rd_ptr != PTR_LAST) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= PTR_LAST);

    assert_last_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_cnt_q <= LAST_LIM) |-> (cascade_o == '0));

    assert_first_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_cnt_q <= FIRST_LIM) |-> (taps_o[W-1:0] == '0));

endmodule

bind ram_tap_delay ram_tap_delay_chk #(
    .W    (DATA_W),
    .M    (TAP_LEN),
    .N    (NUM_TAPS),
    .PTR_W(PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .taps_o   (taps_o),
    .cascade_o(cascade_o),
    .rd_ptr   (rd_ptr)
);

// File: tb/ram_tap_delay_tb.sv
`timescale 1ns/1ps
module ram_tap_delay_tb;

    localparam int W = 8;
    localparam int M = 4;
    localparam int N = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             shift_en = 1'b0;
    logic [W-1:0]     din = '0;
    logic [N*W-1:0]   taps_o;
    logic [W-1:0]     cascade_o;

    int checks = 0;
    int errors = 0;
    string tag = "R3";
    logic [W-1:0] hist[$];
    logic [W-1:0] pend_q[$];
    logic [N*W-1:0] last_exp = '0;

    always #4 clk = ~clk;   // 125 MHz

    ram_tap_delay #(.DATA_W(W), .TAP_LEN(M), .NUM_TAPS(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din),
        .taps_o   (taps_o),
        .cascade_o(cascade_o)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Driver: one shift per call, sample queued for the monitor
    task automatic push(input logic [W-1:0] s);
        @(negedge clk);
        shift_en = 1'b1;
        din      = s;
        pend_q.push_back(s);
    endtask

    // Idle cycles with noise on din
    task automatic hold(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            shift_en = 1'b0;
            din      = W'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        shift_en = 1'b0;
        rst_n    = 1'b0;
        hist.delete();
        pend_q.delete();
        last_exp = '0;
        @(negedge clk);
        check("R1", "taps in reset", 64'(taps_o), 64'(0));
        check("R1", "cascade in reset", 64'(cascade_o), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "taps after release", 64'(taps_o), 64'(0));
    endtask

    function automatic logic [W-1:0] sample_of(input int i);
        return W'(8'h80 | (i * 37 + 11) % 128);
    endfunction

    // Monitor / scoreboard
    initial begin
        forever begin
            bit shifted;
            @(posedge clk);
            shifted = rst_n && shift_en;
            #2;
            if (rst_n) begin
                logic [N*W-1:0] exp_taps;
                string rq_k;
                if (shifted) begin
                    hist.push_back(pend_q.pop_front());
                    for (int k = 0; k < N; k++) begin
                        int idx;
                        idx = hist.size() - 1 - (k + 1) * M;
                        exp_taps[k*W +: W] = (idx >= 0) ? hist[idx] : '0;
                    end
                end else begin
                    exp_taps = last_exp;
                end
                for (int k = 0; k < N; k++) begin
                    if (!shifted) rq_k = "R2";
                    else if (hist.size() <= (k + 1) * M) rq_k = "R4";
                    else rq_k = tag;
                    check(rq_k, $sformatf("tap %0d", k),
                          64'(taps_o[k*W +: W]), 64'(exp_taps[k*W +: W]));
                end
                check("R5", "cascade", 64'(cascade_o),
                      64'(exp_taps[(N-1)*W +: W]));
                last_exp = exp_taps;
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();

        // R3, R6, R7: back-to-back shifts, many pointer wraps, read-during-write
        tag = "R3 R6 R7";
        for (int i = 0; i < 40; i++) push(sample_of(i));

        // R2: idle with noisy din
        hold(6);

        // R8: shifts separated by idle gaps
        tag = "R8";
        for (int i = 40; i < 70; i++) begin
            push(sample_of(i));
            hold(i % 3);
        end
        hold(3);

        // R1 and R4: reset mid-run, then refill edge by edge
        do_reset();
        tag = "R4 R3";
        for (int i = 70; i < 90; i++) push(sample_of(i));
        hold(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule